// File: doc/BRIEF.md
# Three-Byte Serial Frame Transmitter

This block is the host-side master for a 24-bit write-only serial link. A host offers a 24-bit word together with a start strobe. When the block is ready, it captures the word, pulls its active-low frame-select line low and produces a serial clock that runs at a parameterised fraction of the system clock. It then shifts the word out as three back-to-back bytes under one unbroken frame-select pulse. The serial clock idles low and data changes on each rising clock edge, so the data is stable when the receiver samples it on the falling edge.

After the frame, the block holds the frame-select line high and keeps its ready output low until two spacing rules are met. The first is a minimum frame-select high time. The second is a minimum delay from the last falling clock edge to the next frame. A mirror input reverses the bit order inside each byte. A host whose byte engine sends the least significant bit first can therefore pass its bytes through without rework. An abort input ends a frame early, which lets a receiver's discard path be exercised. Half-period, high-time and end-of-frame spacing are all counted in system clocks and checked against minimum values when the design is elaborated.

Top module: `tri_byte_frame_tx`

## Requirements
- R1: Out of reset, sync_n_o is 1, sclk_o is 0 and ready_o is 1.
- R2: With mirror_i at 0, a frame carries exactly 24 bits, taken by the receiver on falling sclk_o edges, starting with word_i bit 23 and ending with bit 0.
- R3: With mirror_i at 1, the bytes still go out high byte first, but each byte is sent from its bit 0 up to its bit 7. The wire order is therefore bits 16..23, then 8..15, then 0..7.
- R4: sclk_o is 0 whenever sync_n_o is 1. The first rising sclk_o edge comes HALF_CYC clocks after sync_n_o falls, and every later high or low phase within the frame lasts HALF_CYC clocks.
- R5: While sync_n_o stays low, sdata_o changes only in the clock where sclk_o rises.
- R6: sync_n_o stays low through all 24 falling sclk_o edges and rises HALF_CYC clocks after the 24th one. No frame has more than 24 falling edges.
- R7: After any frame, sync_n_o stays high for at least SYNC_HIGH_CYC clocks. If start_i is held high, the high time after a full frame is exactly the larger of SYNC_HIGH_CYC and EOF_CYC minus HALF_CYC.
- R8: After a full frame, the next falling edge of sync_n_o comes no sooner than EOF_CYC clocks after the 24th falling sclk_o edge.
- R9: ready_o is low from the clock in which a start is accepted until all spacing rules are met. With start_i held high, sync_n_o falls one clock after ready_o rises. A start_i pulse while ready_o is low starts no frame and does not alter the frame in flight.
- R10: If abort_i is high at a clock edge before the 24th falling sclk_o edge, sync_n_o rises and sclk_o drops at that edge, and only the SYNC_HIGH_CYC rule then governs the next frame. An abort while idle, or after the 24th falling edge, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send word_i; taken only while ready_o is high |
| word_i | input | 24 | Word to send; bits 23..16 form the first byte |
| mirror_i | input | 1 | 1 reverses bit order inside each byte; sampled with the start |
| abort_i | input | 1 | Ends the frame in flight before its 24th bit |
| ready_o | output | 1 | High when a new frame may start |
| sync_n_o | output | 1 | Active-low frame select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Serial data, changes on rising sclk_o |

## Verification
The bench builds the block with HALF_CYC = 2, SYNC_HIGH_CYC = 4 and EOF_CYC = 9. A full frame is only about a hundred clocks long at these values, so many frames fit into a short run. The values also make the end-of-frame rule the tighter one after a complete frame: EOF_CYC minus HALF_CYC gives 7 high clocks, against 4 from SYNC_HIGH_CYC. An aborted frame leaves only the 4-clock high-time rule in force, so both branches of the spacing logic produce distinct, exactly predictable gaps. A two-clock post-frame hold leaves a one-clock window in which a late abort must be ignored.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } tx_state_t;

  // Smallest legal values, in system clocks
  localparam int MIN_HALF_CYC      = 1;
  localparam int MIN_SYNC_HIGH_CYC = 2;
  localparam int MIN_EOF_CYC       = 2;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v
  function automatic int counter_bits(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  // Frame-select high time after a full frame when the next start waits
  function automatic int gap_high_cycles(input int half, input int sync_hi, input int eof);
    return max_int(max_int(sync_hi, eof - half), 2);
  endfunction

endpackage

// File: rtl/tbf_half_timer.sv
module tbf_half_timer import tbf_pkg::*; #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_done_o
);

  localparam int CW = counter_bits(HALF_CYC);
  localparam logic [CW-1:0] END_V = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign half_done_o = run_i && (cnt_q == END_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run_i || half_done_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tbf_word_shifter.sv
module tbf_word_shifter #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          shift_i,
  input  logic                          mirror_i,
  input  logic [BYTE_W*NUM_BYTES-1:0]   word_i,
  output logic                          msb_o
);

  localparam int WORD_W = BYTE_W * NUM_BYTES;

  logic [WORD_W-1:0] mirrored;
  logic [WORD_W-1:0] load_val;
  logic [WORD_W-1:0] sr_q;

  // Reverse bits inside every byte, byte order kept
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign mirrored[b*BYTE_W + i] = word_i[b*BYTE_W + BYTE_W - 1 - i];
    end
  end

  assign load_val = mirror_i ? mirrored : word_i;
  assign msb_o    = sr_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (load_i)  sr_q <= load_val;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

endmodule

// File: rtl/tbf_gap_guard.sv
module tbf_gap_guard import tbf_pkg::*; #(
  parameter int SYNC_HIGH_CYC = 7,
  parameter int EOF_CYC       = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic last_fall_i,   // 24th falling serial clock edge happens at this edge
  input  logic sync_rise_i,   // frame select rises at this edge
  input  logic abort_i,       // frame cut short: end-of-frame spacing waived
  output logic gap_ok_o
);

  localparam int LIM = max_int(SYNC_HIGH_CYC, EOF_CYC);
  localparam int CW  = counter_bits(LIM);
  localparam logic [CW-1:0] LIM_V    = CW'(LIM);
  localparam logic [CW-1:0] HI_NEED  = CW'(SYNC_HIGH_CYC - 1);
  localparam logic [CW-1:0] EOF_NEED = CW'(EOF_CYC - 1);

  logic [CW-1:0] hi_cnt_q;
  logic [CW-1:0] eof_cnt_q;

  // Counts equal edges elapsed since the event; the exit edge adds one more
  assign gap_ok_o = (hi_cnt_q >= HI_NEED) && (eof_cnt_q >= EOF_NEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q  <= LIM_V;
      eof_cnt_q <= LIM_V;
    end else begin
      if (sync_rise_i)           hi_cnt_q <= CW'(1);
      else if (hi_cnt_q != LIM_V) hi_cnt_q <= hi_cnt_q + 1'b1;

      if (abort_i)                eof_cnt_q <= LIM_V;
      else if (last_fall_i)       eof_cnt_q <= CW'(1);
      else if (eof_cnt_q != LIM_V) eof_cnt_q <= eof_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tri_byte_frame_tx.sv
module tri_byte_frame_tx import tbf_pkg::*; #(
  parameter int HALF_CYC      = 3,
  parameter int SYNC_HIGH_CYC = 7,
  parameter int EOF_CYC       = 13,
  parameter int BYTE_W        = 8,
  parameter int NUM_BYTES     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] word_i,
  input  logic                        mirror_i,
  input  logic                        abort_i,
  output logic                        ready_o,
  output logic                        sync_n_o,
  output logic                        sclk_o,
  output logic                        sdata_o
);

  localparam int WORD_W = BYTE_W * NUM_BYTES;
  localparam int BIT_CW = counter_bits(WORD_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(WORD_W);
  localparam logic [BIT_CW-1:0] PENULT   = BIT_CW'(WORD_W - 1);

  // Build-time checks of the timing parameters
  if (HALF_CYC < MIN_HALF_CYC) begin : g_bad_half
    $error("HALF_CYC below minimum");
  end
  if (SYNC_HIGH_CYC < MIN_SYNC_HIGH_CYC) begin : g_bad_sync
    $error("SYNC_HIGH_CYC below minimum");
  end
  if (EOF_CYC < MIN_EOF_CYC) begin : g_bad_eof
    $error("EOF_CYC below minimum");
  end

  tx_state_t         state_q, state_d;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic              sync_n_q;
  logic              sclk_q;

  // Named internal events
  logic in_frame, half_done, accept, bits_all, abort_take;
  logic rise_evt, shift_evt, fall_evt, last_fall, frame_end, sync_rise, gap_ok;

  assign in_frame   = (state_q == ST_LEAD) || (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign accept     = (state_q == ST_IDLE) && start_i;
  assign bits_all   = (bit_cnt_q == LAST_BIT);
  assign abort_take = abort_i && in_frame && !((state_q == ST_LOW) && bits_all);
  assign rise_evt   = !abort_take && half_done &&
                      ((state_q == ST_LEAD) || ((state_q == ST_LOW) && !bits_all));
  assign shift_evt  = rise_evt && (state_q == ST_LOW);
  assign fall_evt   = !abort_take && half_done && (state_q == ST_HIGH);
  assign last_fall  = fall_evt && (bit_cnt_q == PENULT);
  assign frame_end  = half_done && (state_q == ST_LOW) && bits_all;
  assign sync_rise  = frame_end || abort_take;

  tbf_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (in_frame),
    .half_done_o (half_done)
  );

  tbf_word_shifter #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .shift_i  (shift_evt),
    .mirror_i (mirror_i),
    .word_i   (word_i),
    .msb_o    (sdata_o)
  );

  tbf_gap_guard #(.SYNC_HIGH_CYC(SYNC_HIGH_CYC), .EOF_CYC(EOF_CYC)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_fall_i (last_fall),
    .sync_rise_i (sync_rise),
    .abort_i     (abort_take),
    .gap_ok_o    (gap_ok)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LEAD;
      ST_LEAD, ST_HIGH, ST_LOW: begin
        if (abort_take)     state_d = ST_GAP;
        else if (rise_evt)  state_d = ST_HIGH;
        else if (fall_evt)  state_d = ST_LOW;
        else if (frame_end) state_d = ST_GAP;
      end
      ST_GAP:  if (gap_ok) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sync_n_q  <= 1'b1;
      sclk_q    <= 1'b0;
    end else begin
      state_q <= state_d;

      if (accept)        bit_cnt_q <= '0;
      else if (fall_evt) bit_cnt_q <= bit_cnt_q + 1'b1;

      if (accept)         sync_n_q <= 1'b0;
      else if (sync_rise) sync_n_q <= 1'b1;

      if (abort_take || fall_evt) sclk_q <= 1'b0;
      else if (rise_evt)          sclk_q <= 1'b1;
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign sync_n_o = sync_n_q;
  assign sclk_o   = sclk_q;

endmodule

// File: rtl/tbf_frame_checker.sv
module tbf_frame_checker #(
  parameter int HALF_CYC      = 3,
  parameter int SYNC_HIGH_CYC = 7,
  parameter int EOF_CYC       = 13,
  parameter int WORD_W        = 24
) (
  input logic clk,
  input logic rst_n,
  input logic abort_i,
  input logic ready_o,
  input logic sync_n_o,
  input logic sclk_o,
  input logic sdata_o
);

  localparam int SAT = 1 << 20;

  int   hi_cnt;     // edges with frame select seen high since it was last low
  int   eof_cnt;    // edges since the last falling serial clock edge
  int   nfall;      // falling serial clock edges in the current frame
  logic prev_sclk;
  logic prev_sync;
  logic last_full;  // previous frame carried all its bits

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= SAT;
      eof_cnt   <= SAT;
      nfall     <= 0;
      prev_sclk <= 1'b0;
      prev_sync <= 1'b1;
      last_full <= 1'b0;
    end else begin
      prev_sclk <= sclk_o;
      prev_sync <= sync_n_o;
      if (!sync_n_o)        hi_cnt <= 0;
      else if (hi_cnt < SAT) hi_cnt <= hi_cnt + 1;
      if (prev_sclk && !sclk_o) eof_cnt <= 1;
      else if (eof_cnt < SAT)   eof_cnt <= eof_cnt + 1;
      if (sync_n_o)                  nfall <= 0;
      else if (prev_sclk && !sclk_o) nfall <= nfall + 1;
      if (sync_n_o && !prev_sync) last_full <= (nfall == WORD_W);
    end
  end

  assert_clock_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_o |-> !sclk_o);

  assert_data_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n_o && $past(!sync_n_o) && !$rose(sclk_o)) |-> $stable(sdata_o));

  assert_start_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n_o) |-> $past(ready_o));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> !ready_o);

  assert_sync_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n_o) |-> (hi_cnt >= SYNC_HIGH_CYC));

  assert_eof_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_n_o) && last_full) |-> (eof_cnt >= EOF_CYC));

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_n_o) && !$past(abort_i)) |-> (nfall == WORD_W));

  assert_no_extra_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nfall <= WORD_W);

endmodule

bind tri_byte_frame_tx tbf_frame_checker #(
  .HALF_CYC      (HALF_CYC),
  .SYNC_HIGH_CYC (SYNC_HIGH_CYC),
  .EOF_CYC       (EOF_CYC),
  .WORD_W        (WORD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort_i  (abort_i),
  .ready_o  (ready_o),
  .sync_n_o (sync_n_o),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o)
);

// File: tb/sim_tri_byte_frame_tx.sv
module sim_tri_byte_frame_tx;

  localparam int H  = 2;
  localparam int S  = 4;
  localparam int E  = 9;
  localparam int GAP_FULL = (S > E - H) ? S : E - H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] word_i = '0;
  logic        mirror_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        ready_o, sync_n_o, sclk_o, sdata_o;

  always #4 clk = ~clk;

  tri_byte_frame_tx #(.HALF_CYC(H), .SYNC_HIGH_CYC(S), .EOF_CYC(E)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .mirror_i(mirror_i), .abort_i(abort_i), .ready_o(ready_o),
    .sync_n_o(sync_n_o), .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Receiver-side monitor, sampled on the falling system clock edge
  int cyc = 0, fall_cyc = 0, rise_cyc = 0, last_fall_cyc = 0, first_rise_cyc = -1;
  int ready_rise_cyc = 0, last_edge = 0;
  int nbits = 0, frame_bits = 0, n_started = 0, n_done = 0;
  int phase_err = 0, data_err = 0, idle_err = 0;
  logic [23:0] cap = '0, frame_word = '0;
  logic p_sync = 1'b1, p_sclk = 1'b0, p_sdata = 1'b0, p_ready = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!p_ready && ready_o) ready_rise_cyc = cyc;
      if (sync_n_o && sclk_o) idle_err++;
      if (p_sync && !sync_n_o) begin
        fall_cyc = cyc; last_edge = cyc; nbits = 0; cap = '0;
        first_rise_cyc = -1; n_started++;
      end
      if (!sync_n_o && !p_sync) begin
        if (sclk_o != p_sclk) begin
          if (cyc - last_edge != H) phase_err++;
          last_edge = cyc;
        end
        if (!p_sclk && sclk_o && first_rise_cyc < 0) first_rise_cyc = cyc;
        if (p_sclk && !sclk_o) begin
          cap = {cap[22:0], p_sdata}; nbits++; last_fall_cyc = cyc;
        end
        if ((sdata_o != p_sdata) && !(!p_sclk && sclk_o)) data_err++;
      end
      if (!p_sync && sync_n_o) begin
        rise_cyc = cyc; frame_bits = nbits; frame_word = cap; n_done++;
      end
      p_sync = sync_n_o; p_sclk = sclk_o; p_sdata = sdata_o; p_ready = ready_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [23:0] wire_order(input logic [23:0] w, input bit m);
    logic [23:0] r;
    r = w;
    if (m) begin
      for (int b = 0; b < 3; b++)
        for (int i = 0; i < 8; i++)
          r[b*8 + i] = w[b*8 + 7 - i];
    end
    return r;
  endfunction

  task automatic start_frame(input logic [23:0] w, input bit m);
    while (!ready_o) step();
    word_i = w; mirror_i = m; start_i = 1'b1;
    step();
    start_i = 1'b0;
    check(ready_o == 1'b0, "R9 ready low after accept", ready_o, 0);
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) step();
  endtask

  task automatic t_reset();
    check(sync_n_o == 1'b1, "R1 sync_n after reset", sync_n_o, 1);
    check(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
    check(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
  endtask

  task automatic t_frame(input logic [23:0] w, input bit m);
    int d0;
    d0 = n_done;
    start_frame(w, m);
    wait_done(d0 + 1);
    if (m) check(frame_word == wire_order(w, 1), "R3 mirrored byte order", frame_word, wire_order(w, 1));
    else   check(frame_word == w, "R2 msb-first word", frame_word, w);
    check(frame_bits == 24, "R6 bit count", frame_bits, 24);
    check(first_rise_cyc - fall_cyc == H, "R4 lead time", first_rise_cyc - fall_cyc, H);
    check(rise_cyc - last_fall_cyc == H, "R6 sync rise after last fall", rise_cyc - last_fall_cyc, H);
  endtask

  task automatic t_back_to_back(input logic [23:0] a, input logic [23:0] b);
    int d0, s0, r1, lf1;
    logic [23:0] w1;
    d0 = n_done; s0 = n_started;
    while (!ready_o) step();
    word_i = a; mirror_i = 1'b0; start_i = 1'b1;
    step();
    wait_done(d0 + 1);
    r1 = rise_cyc; lf1 = last_fall_cyc; w1 = frame_word;
    word_i = b;
    while (n_started < s0 + 2) step();
    start_i = 1'b0;
    check(w1 == a, "R2 first of pair", w1, a);
    check(fall_cyc - r1 == GAP_FULL, "R7 held-start high time", fall_cyc - r1, GAP_FULL);
    check(fall_cyc - lf1 == E, "R8 end-of-frame spacing", fall_cyc - lf1, E);
    check(fall_cyc - ready_rise_cyc == 1, "R9 start one clock after ready", fall_cyc - ready_rise_cyc, 1);
    wait_done(d0 + 2);
    check(frame_word == b, "R2 second of pair", frame_word, b);
  endtask

  task automatic t_busy_start(input logic [23:0] x, input logic [23:0] y);
    int d0, s0;
    d0 = n_done; s0 = n_started;
    start_frame(x, 0);
    repeat (20) step();
    word_i = y; start_i = 1'b1;
    step();
    start_i = 1'b0;
    wait_done(d0 + 1);
    check(frame_word == x, "R9 frame unchanged by busy start", frame_word, x);
    repeat (30) step();
    check(n_started == s0 + 1, "R9 busy start ignored", n_started - s0, 1);
  endtask

  task automatic t_abort(input logic [23:0] w, input logic [23:0] v);
    int d0, s0;
    d0 = n_done; s0 = n_started;
    start_frame(w, 0);
    while (nbits < 10) step();
    abort_i = 1'b1;
    step();
    abort_i = 1'b0;
    wait_done(d0 + 1);
    check(frame_bits == 10, "R10 abort truncates frame", frame_bits, 10);
    check(sclk_o == 1'b0, "R10 clock low after abort", sclk_o, 0);
    word_i = v; start_i = 1'b1;
    while (n_started < s0 + 2) step();
    start_i = 1'b0;
    check(fall_cyc - rise_cyc == S, "R10 only high-time rule after abort", fall_cyc - rise_cyc, S);
    wait_done(d0 + 2);
    check(frame_word == v, "R10 frame after abort", frame_word, v);
  endtask

  task automatic t_abort_ignored(input logic [23:0] w);
    int d0, s0;
    while (!ready_o) step();
    s0 = n_started;
    abort_i = 1'b1;
    repeat (3) step();
    abort_i = 1'b0;
    check(ready_o == 1'b1 && sync_n_o == 1'b1, "R10 idle abort ignored", {ready_o, sync_n_o}, 3);
    check(n_started == s0, "R10 idle abort starts nothing", n_started - s0, 0);
    d0 = n_done;
    start_frame(w, 0);
    while (nbits < 24) step();
    abort_i = 1'b1;
    step();
    abort_i = 1'b0;
    wait_done(d0 + 1);
    check(rise_cyc - last_fall_cyc == H, "R10 late abort ignored", rise_cyc - last_fall_cyc, H);
    check(frame_word == w, "R10 late abort word intact", frame_word, w);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_frame(24'hC35A0F, 0);
    t_frame(24'h800001, 0);
    t_frame(24'h6E19B4, 0);
    t_frame(24'h01807E, 1);
    t_frame(24'hA3C5F0, 1);
    t_back_to_back(24'h123456, 24'hFEDCBA);
    t_busy_start(24'h0F0F0F, 24'hF0F0F0);
    t_abort(24'hAAAAAA, 24'h5A5A5A);
    t_abort_ignored(24'h3C3C3C);
    repeat (12) step();
    check(phase_err == 0, "R4 half-period length", phase_err, 0);
    check(idle_err == 0, "R4 clock low while deselected", idle_err, 0);
    check(data_err == 0, "R5 data changes only on rising clock", data_err, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule